// File: doc/BRIEF.md
# Line Error Counter Bank

This block keeps two counters that measure receive-line quality on a 2.048 Mb/s framed link. A 16-bit counter counts bipolar (line code) violations. A 10-bit counter counts CRC-4 check failures. The receive path marks each error with a one-cycle strobe. The CRC strobe fires at most twice per receive multiframe, so one increment per cycle is always enough.

Software reaches both counters through a byte-wide register port, and can read, preset or clear them there. A counter wider than one byte is loaded in two steps. The low byte goes into a staging register first. Writing the high byte then loads both bytes into the counter at once. Reading the low byte captures a snapshot of the high byte, so a later high-byte read matches the low byte that was read.

Each counter has two interrupt sources: one for a toggle of its least significant bit (which happens on every increment) and one for a wrap to zero. These four sources set sticky flags. Software clears a flag by writing 1 to it. A mask register gates the flags onto one interrupt line. The register port is a plain strobe interface with no back-pressure. A read or write strobe is accepted in the cycle it is high. The error strobes cannot be stalled either.

Top module: `line_err_counters`

## Requirements
- R1: Each `bv_err` pulse raises the 16-bit violation count by exactly one, wrapping from FFFFh to 0000h.
- R2: Each `crc_err` pulse raises the 10-bit CRC count by exactly one, wrapping from 3FFh to 000h.
- R3: Software loads a counter in two steps. A write to its low-byte address (0 = violation, 2 = CRC) only stages the byte and leaves the count unchanged. A following write to its high-byte address (1 = violation, 3 = CRC; the CRC count uses data bits 1:0) loads both bytes together.
- R4: When an error pulse arrives in the same cycle as a high-byte write to that counter, the count takes the written value and the increment is lost.
- R5: Every increment sets the toggle flag of that counter: flag bit 0 for the violation counter, bit 2 for the CRC counter.
- R6: A wrap to zero from an increment sets the overflow flag: bit 1 for the violation counter, bit 3 for the CRC counter.
- R7: Writing to address 4 clears each flag whose data bit is 1. A flag that is set and cleared in the same cycle ends up set.
- R8: Address 5 holds the mask, which resets to 0, with one bit per flag using the flag bit positions. `irq` is high exactly when some flag is set and its mask bit is 1.
- R9: Reading a low-byte address captures the high byte. A later read of the matching high-byte address returns that captured value, even if the count has changed since.
- R10: After reset both counts, all flags and the mask are zero.
- R11: Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. Addresses 4 and 5 return the flags and the mask in bits 3:0. The CRC high byte returns count bits 9:8 in bits 1:0, with zeros above. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bv_err | input | 1 | One-cycle bipolar-violation event |
| crc_err | input | 1 | One-cycle CRC-4 error event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt, OR of unmasked flags |

## Verification
If a count is off by one, is skipped or takes a bad preset, the next low-byte read shows a wrong value, one cycle after the read strobe. If the staging register or the high-byte snapshot goes wrong, the damage stays hidden until a high-byte write or read, which then returns a value that does not match the low byte. A flag that is never set, or that clears itself, shows on `irq` in the cycle after the causing event, provided the mask bit is 1. Otherwise it shows on the next read of address 4.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int BV_W     = 16;
  localparam int CRC_W    = 10;
  localparam int NFLAG    = 4;

  localparam logic [ADDR_W-1:0] A_BV_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] A_BV_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CRC_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CRC_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK    = 3'd5;

  localparam int F_BV_TOG  = 0;
  localparam int F_BV_WRAP = 1;
  localparam int F_CRC_TOG = 2;
  localparam int F_CRC_WRAP = 3;
endpackage

// File: rtl/lec_counter.sv
module lec_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          rd_lo,
  input  logic [7:0]    lo_wdata,
  input  logic [CW-9:0] hi_wdata,
  output logic [CW-1:0] count,
  output logic [7:0]    hi_snap,
  output logic          tog_pulse,
  output logic          wrap_pulse
);
  localparam int HW = CW - 8;

  logic [7:0] stage;
  logic [7:0] hi_ext;
  logic       bump;

  // an increment is lost when software commits a value the same cycle
  assign bump       = evt && !wr_hi;
  assign tog_pulse  = bump;
  assign wrap_pulse = bump && (&count);

  always_comb begin
    hi_ext = '0;
    hi_ext[HW-1:0] = count[CW-1:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      stage   <= '0;
      hi_snap <= '0;
    end else begin
      if (wr_lo) stage <= lo_wdata;
      if (wr_hi)     count <= {hi_wdata, stage};
      else if (bump) count <= count + 1'b1;
      if (rd_lo) hi_snap <= hi_ext;
    end
  end
endmodule

// File: rtl/lec_irq.sv
module lec_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  input  logic         clr_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_wr ? wdata : '0;
  assign irq      = |(flags & mask);

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)           flags[i] <= 1'b0;
        else if (set_in[i])   flags[i] <= 1'b1;
        else if (clr_bits[i]) flags[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_wr) mask <= wdata;
  end
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters
  import lec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bv_err,
  input  logic              crc_err,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int BV_HW  = BV_W - 8;
  localparam int CRC_HW = CRC_W - 8;

  logic [BV_W-1:0]  bv_count;
  logic [CRC_W-1:0] crc_count;
  logic [7:0]       bv_snap, crc_snap;
  logic             bv_tog, bv_wrap, crc_tog, crc_wrap;
  logic [NFLAG-1:0] flags, mask, set_vec;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic hit(input logic strobe, input logic [ADDR_W-1:0] a,
                               input logic [ADDR_W-1:0] want);
    return strobe && (a == want);
  endfunction

  lec_counter #(.CW(BV_W)) u_bv (
    .clk(clk), .rst_n(rst_n), .evt(bv_err),
    .wr_lo(hit(reg_wr, reg_addr, A_BV_LO)),
    .wr_hi(hit(reg_wr, reg_addr, A_BV_HI)),
    .rd_lo(hit(reg_rd, reg_addr, A_BV_LO)),
    .lo_wdata(reg_wdata), .hi_wdata(reg_wdata[BV_HW-1:0]),
    .count(bv_count), .hi_snap(bv_snap),
    .tog_pulse(bv_tog), .wrap_pulse(bv_wrap)
  );

  lec_counter #(.CW(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .evt(crc_err),
    .wr_lo(hit(reg_wr, reg_addr, A_CRC_LO)),
    .wr_hi(hit(reg_wr, reg_addr, A_CRC_HI)),
    .rd_lo(hit(reg_rd, reg_addr, A_CRC_LO)),
    .lo_wdata(reg_wdata), .hi_wdata(reg_wdata[CRC_HW-1:0]),
    .count(crc_count), .hi_snap(crc_snap),
    .tog_pulse(crc_tog), .wrap_pulse(crc_wrap)
  );

  always_comb begin
    set_vec = '0;
    set_vec[F_BV_TOG]   = bv_tog;
    set_vec[F_BV_WRAP]  = bv_wrap;
    set_vec[F_CRC_TOG]  = crc_tog;
    set_vec[F_CRC_WRAP] = crc_wrap;
  end

  lec_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_in(set_vec),
    .clr_wr(hit(reg_wr, reg_addr, A_FLAGS)),
    .mask_wr(hit(reg_wr, reg_addr, A_MASK)),
    .wdata(reg_wdata[NFLAG-1:0]),
    .flags(flags), .mask(mask), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_BV_LO:  rd_mux = bv_count[7:0];
      A_BV_HI:  rd_mux = bv_snap;
      A_CRC_LO: rd_mux = crc_count[7:0];
      A_CRC_HI: rd_mux = crc_snap;
      A_FLAGS:  rd_mux[NFLAG-1:0] = flags;
      A_MASK:   rd_mux[NFLAG-1:0] = mask;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/lec_checker.sv
module lec_checker
  import lec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bv_err,
  input logic              crc_err,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [BV_W-1:0]   bv_count,
  input logic [CRC_W-1:0]  crc_count,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  mask,
  input logic              irq
);
  logic bv_hi_wr, crc_hi_wr, bv_lo_wr, crc_lo_wr;
  assign bv_hi_wr  = reg_wr && reg_addr == A_BV_HI;
  assign crc_hi_wr = reg_wr && reg_addr == A_CRC_HI;
  assign bv_lo_wr  = reg_wr && reg_addr == A_BV_LO;
  assign crc_lo_wr = reg_wr && reg_addr == A_CRC_LO;

  assert_bv_incr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bv_err && !bv_hi_wr |=> bv_count == $past(bv_count) + 16'd1);

  assert_crc_incr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !crc_hi_wr |=> crc_count == $past(crc_count) + 10'd1);

  assert_lo_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bv_lo_wr && !bv_err |=> $stable(bv_count));

  assert_crc_lo_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crc_lo_wr && !crc_err |=> $stable(crc_count));

  assert_commit_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bv_hi_wr |=> bv_count[15:8] == $past(reg_wdata));

  assert_bv_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bv_err && !bv_hi_wr && bv_count == 16'hFFFF |=> flags[F_BV_WRAP]);

  assert_tog_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !crc_hi_wr |=> flags[F_CRC_TOG]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask == '0 |-> !irq);
endmodule

bind line_err_counters lec_checker u_lec_checker (
  .clk(clk), .rst_n(rst_n), .bv_err(bv_err), .crc_err(crc_err),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .bv_count(bv_count), .crc_count(crc_count), .flags(flags),
  .mask(mask), .irq(irq)
);

// File: tb/line_err_counters_bench.sv
module line_err_counters_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv_err = 1'b0, crc_err = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;
  logic rd_q = 1'b0;
  logic done = 1'b0;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  line_err_counters u_line_err_counters (
    .clk(clk), .rst_n(rst_n), .bv_err(bv_err), .crc_err(crc_err),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: a read accepted at a posedge shows its data by the next negedge
  always @(posedge clk) rd_q <= reg_rd;
  always @(negedge clk) begin
    if (rd_q) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(reg_rdata) != e) begin
        errors++;
        $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e[7:0]);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d,
                    input logic be, input logic ce);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; bv_err = be; crc_err = ce;
    @(negedge clk);
    reg_wr = 1'b0; bv_err = 1'b0; crc_err = 1'b0;
  endtask

  task automatic pulse(input logic be, input logic ce, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bv_err = be; crc_err = ce;
      @(negedge clk);
      bv_err = 1'b0; crc_err = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), 0, "R10 reset");
    chk_irq(1'b0, "R10 irq reset");
    // R1 counting
    pulse(1'b1, 1'b0, 5);
    rd(3'd0, 5, "R1 five events");
    rd(3'd4, 8'h01, "R5 bv toggle flag");
    chk_irq(1'b0, "R8 mask zero");
    wr(3'd5, 8'h0F, 1'b0, 1'b0);
    chk_irq(1'b1, "R8 unmasked flag");
    wr(3'd4, 8'h01, 1'b0, 1'b0);
    chk_irq(1'b0, "R7 flag cleared");
    rd(3'd4, 8'h00, "R7 flags read after clear");
    // R3 staging
    wr(3'd0, 8'hFE, 1'b0, 1'b0);
    rd(3'd0, 5, "R3 low write only stages");
    wr(3'd1, 8'hFF, 1'b0, 1'b0);
    rd(3'd0, 8'hFE, "R3 commit low");
    rd(3'd1, 8'hFF, "R3 commit high");
    // R6 wrap FFFF->0000
    pulse(1'b1, 1'b0, 2);
    rd(3'd4, 8'h03, "R6 bv wrap and toggle flags");
    rd(3'd0, 8'h00, "R1 wrap low");
    rd(3'd1, 8'h00, "R1 wrap high");
    // R9 snapshot
    wr(3'd0, 8'hFF, 1'b0, 1'b0);
    wr(3'd1, 8'h12, 1'b0, 1'b0);
    rd(3'd0, 8'hFF, "R9 low read");
    pulse(1'b1, 1'b0, 1);
    rd(3'd1, 8'h12, "R9 high from snapshot");
    rd(3'd0, 8'h00, "R9 low after carry");
    rd(3'd1, 8'h13, "R9 new snapshot");
    // R4 commit beats event
    wr(3'd0, 8'h34, 1'b0, 1'b0);
    wr(3'd1, 8'h00, 1'b1, 1'b0);
    rd(3'd0, 8'h34, "R4 written value wins");
    rd(3'd1, 8'h00, "R4 high byte");
    // R2 / R6 CRC wrap
    wr(3'd4, 8'h0F, 1'b0, 1'b0);
    wr(3'd2, 8'hFE, 1'b0, 1'b0);
    wr(3'd3, 8'h03, 1'b0, 1'b0);
    pulse(1'b0, 1'b1, 2);
    rd(3'd4, 8'h0C, "R6 crc wrap and toggle flags");
    rd(3'd2, 8'h00, "R2 crc wrap low");
    rd(3'd3, 8'h00, "R2 crc wrap high");
    pulse(1'b0, 1'b1, 3);
    rd(3'd2, 8'h03, "R2 three crc events");
    // R11 crc high byte packing
    wr(3'd2, 8'h55, 1'b0, 1'b0);
    wr(3'd3, 8'hFE, 1'b0, 1'b0);
    rd(3'd2, 8'h55, "R11 crc low");
    rd(3'd3, 8'h02, "R11 crc high bits 9:8 only");
    rd(3'd6, 8'h00, "R11 unused address");
    // R7 set beats clear
    wr(3'd4, 8'h0F, 1'b1, 1'b0);
    rd(3'd4, 8'h01, "R7 set wins over clear");
    rd(3'd5, 8'h0F, "R11 mask readback");
    wr(3'd5, 8'h02, 1'b0, 1'b0);
    chk_irq(1'b0, "R8 flag masked off");
    wr(3'd5, 8'h01, 1'b0, 1'b0);
    chk_irq(1'b1, "R8 flag unmasked");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule